// File: doc/BRIEF.md
# Wake Event and System Control Interrupt Controller

This block gathers power-management wake events and turns them into a level-sensitive system control interrupt (`sci`) and a power-on control output (`onctl`). There are three kinds of source. First, `N_PIN` general wake pins, each with its own trigger condition. Second, a power button input that triggers on its rising edge. Third, an alarm-match input supplied by an external timekeeping datapath. Every source has a sticky status bit and an enable bit. Both are reachable over a byte-wide register bus that has a single-cycle write strobe and a combinational read port.

A status bit records its event whether or not the source is enabled. Only the enabled status bits raise `sci` or act on the power state. Software keeps a suspend flag. An enabled event that arrives while the flag is set raises a wake flag and drops the suspend flag.

A software power-off command lowers `onctl`. It does so either at once or after `OFF_DELAY` clock cycles, depending on a delay-enable bit written with the command. An enabled event during the delay cancels the power-off. An enabled event while power is off raises `onctl` again.

Top module: `wake_sci_ctrl`

Register map. Addresses are on `reg_addr`, and unmapped addresses read 0.
- Address 0 is status. Bit i (0..N_PIN-1) is wake pin i, bit N_PIN is the button and bit N_PIN+1 is the alarm. The bits are write-one-to-clear.
- Address 1 is enable. It uses the same bit layout and is read/write.
- Address 2 is control. Bit 0 is the suspend flag. Bit 1 is the delay enable. Writing 1 to bit 2 issues power-off, and bit 2 reads back as "delay running". Bit 7 is the wake flag, which is write-one-to-clear.
- Address 4+i holds the trigger code of pin i in bits [2:0].

## Requirements
- R1: After reset, all status, enable and trigger registers read 0, the control register reads 0, `sci` is 0 and `onctl` is 1.
- R2: The trigger code of pin i is read and written at address 4+i in bits [2:0]. The codes are 1 = low level, 2 = high level, 3 = falling edge, 4 = rising edge, 5 = either edge, and 0, 6, 7 = never.
- R3: An edge trigger sets status once per edge, so a pin held steady does not set it again after a clear. A level trigger keeps setting status for as long as the level holds.
- R4: A status bit is set by its event even when its enable bit is 0, and in that case it does not raise `sci`.
- R5: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. If an event and a clear fall in the same cycle, the status bit stays 1.
- R6: `sci` is the OR of (status AND enable) over all sources. It remains high until software clears the status or the enable.
- R7: A rising edge on `pwr_btn` sets status bit N_PIN. `alarm_hit` high at a clock edge sets status bit N_PIN+1.
- R8: The wake flag (control bit 7) is set only when the suspend flag is 1 and an enabled event arrives. The same event clears the suspend flag. The wake flag is cleared by writing 1 to bit 7.
- R9: A power-off command with bit 1 = 0 lowers `onctl` at the write's clock edge. With bit 1 = 1, `onctl` falls exactly `OFF_DELAY` cycles after that edge.
- R10: An enabled event during the delay cancels the power-off and keeps `onctl` at 1. An enabled event while `onctl` is 0 raises it to 1.
- R11: Status and enable bits above N_PIN+1, and control bits 3 to 6, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wake_pin | input | N_PIN | Asynchronous wake pins |
| pwr_btn | input | 1 | Asynchronous power button, pressed = 1 |
| alarm_hit | input | 1 | Synchronous alarm-match indication |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| sci | output | 1 | System control interrupt, level |
| onctl | output | 1 | Power-on control, 1 = power on |

## Verification
The verification concern is two functions acting in the same cycle. A hardware event that sets a status bit can coincide with a software write-one-to-clear of that bit. To provoke this, the bench holds `alarm_hit` high, which is a level source, while it writes the clear. It judges the result by reading the bit back as 1. In the same way, an enabled event that lands inside the switch-off delay competes with the delay counter. The bench pulses the alarm in the middle of the delay and requires `onctl` to still be 1 and the delay flag to be clear well after the delay would have expired. Random pin trials with random trigger codes, start levels and enables are scored by bench functions that compute level and edge matches directly from the requirement encoding.

// File: rtl/wake_sci_ctrl.sv
module wake_sci_ctrl #(
  parameter int N_PIN     = 4,
  parameter int OFF_DELAY = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_PIN-1:0] wake_pin,
  input  logic             pwr_btn,
  input  logic             alarm_hit,
  input  logic             reg_wr,
  input  logic [3:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             sci,
  output logic             onctl
);
  localparam int NSRC = N_PIN + 2;
  localparam int CW   = $clog2(OFF_DELAY + 1);

  logic [N_PIN:0]    sy1, sy2, prv;
  logic [NSRC-1:0]   set_v, sts, en_r;
  logic [2:0]        cfg [N_PIN];
  logic              susp, dly_en, wk, counting;
  logic [CW-1:0]     cnt;
  logic              hit;

  wire wr_sts = reg_wr && (reg_addr == 4'd0);
  wire wr_en  = reg_wr && (reg_addr == 4'd1);
  wire wr_ctl = reg_wr && (reg_addr == 4'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sy1 <= '0;
      sy2 <= '0;
      prv <= '0;
    end else begin
      sy1 <= {pwr_btn, wake_pin};
      sy2 <= sy1;
      prv <= sy2;
    end
  end

  for (genvar i = 0; i < N_PIN; i++) begin : g_trig
    always_comb begin
      case (cfg[i])
        3'd1:    set_v[i] = ~sy2[i];
        3'd2:    set_v[i] =  sy2[i];
        3'd3:    set_v[i] = ~sy2[i] &  prv[i];
        3'd4:    set_v[i] =  sy2[i] & ~prv[i];
        3'd5:    set_v[i] =  sy2[i] ^  prv[i];
        default: set_v[i] = 1'b0;
      endcase
    end
  end
  assign set_v[N_PIN]   = sy2[N_PIN] & ~prv[N_PIN];
  assign set_v[N_PIN+1] = alarm_hit;

  assign hit = |(set_v & en_r);
  assign sci = |(sts & en_r);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts  <= '0;
      en_r <= '0;
    end else begin
      sts <= (sts & ~(wr_sts ? reg_wdata[NSRC-1:0] : '0)) | set_v;
      if (wr_en) en_r <= reg_wdata[NSRC-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_PIN; i++) cfg[i] <= 3'd0;
    end else begin
      for (int i = 0; i < N_PIN; i++)
        if (reg_wr && reg_addr == 4'(4 + i)) cfg[i] <= reg_wdata[2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      susp   <= 1'b0;
      dly_en <= 1'b0;
      wk     <= 1'b0;
    end else begin
      if (wr_ctl) begin
        susp   <= reg_wdata[0];
        dly_en <= reg_wdata[1];
        if (reg_wdata[7]) wk <= 1'b0;
      end
      if (susp && hit) begin
        wk   <= 1'b1;
        susp <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      onctl    <= 1'b1;
      counting <= 1'b0;
      cnt      <= '0;
    end else if (!onctl) begin
      if (hit) onctl <= 1'b1;
    end else if (counting) begin
      if (hit) begin
        counting <= 1'b0;
      end else if (cnt == '0) begin
        onctl    <= 1'b0;
        counting <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else if (wr_ctl && reg_wdata[2] && !hit) begin
      if (reg_wdata[1]) begin
        counting <= 1'b1;
        cnt      <= CW'(OFF_DELAY - 1);
      end else begin
        onctl <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata = 8'd0;
    case (reg_addr)
      4'd0:    reg_rdata[NSRC-1:0] = sts;
      4'd1:    reg_rdata[NSRC-1:0] = en_r;
      4'd2:    reg_rdata = {wk, 4'b0000, counting, dly_en, susp};
      default: begin
        for (int i = 0; i < N_PIN; i++)
          if (reg_addr == 4'(4 + i)) reg_rdata[2:0] = cfg[i];
      end
    endcase
  end
endmodule

// File: rtl/wake_sci_ctrl_chk.sv
module wake_sci_ctrl_chk #(
  parameter int N_PIN = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [3:0]        reg_addr,
  input logic [7:0]        reg_wdata,
  input logic [7:0]        reg_rdata,
  input logic              sci,
  input logic              onctl,
  input logic [N_PIN+1:0]  sts,
  input logic [N_PIN+1:0]  en_r,
  input logic [N_PIN+1:0]  set_v,
  input logic              susp,
  input logic              wk,
  input logic              counting
);
  localparam logic [7:0] SMASK = 8'((1 << (N_PIN + 2)) - 1);

  AST_STS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == 4'd0) |=> ((sts & $past(sts)) == $past(sts))); // R5

  AST_SCI_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (en_r == '0) |-> !sci); // R6

  AST_WAKE_IN_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wk) |-> $past(susp)); // R8

  AST_OFF_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (onctl && !counting && reg_wr && reg_addr == 4'd2 && reg_wdata[2] &&
     !reg_wdata[1] && !(|(set_v & en_r))) |=> !onctl); // R9

  AST_ON_NEEDS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(onctl) |-> $past(|(set_v & en_r))); // R10

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 4'd0 || reg_addr == 4'd1) |-> ((reg_rdata & ~SMASK) == 8'd0)); // R11

  AST_CTL_RSV: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 4'd2) |-> (reg_rdata[6:3] == 4'd0)); // R11
endmodule

bind wake_sci_ctrl wake_sci_ctrl_chk #(.N_PIN(N_PIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sci(sci), .onctl(onctl),
  .sts(sts), .en_r(en_r), .set_v(set_v), .susp(susp), .wk(wk),
  .counting(counting)
);

// File: tb/wake_sci_ctrl_test.sv
`timescale 1ns/1ps
module wake_sci_ctrl_test;
  localparam int NP = 4;
  localparam int D  = 20;

  logic clk = 0, rst_n = 0;
  logic [NP-1:0] wake_pin = '0;
  logic pwr_btn = 0, alarm_hit = 0, reg_wr = 0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic sci, onctl;
  int total = 0, bad = 0;
  bit done = 0;

  wake_sci_ctrl #(.N_PIN(NP), .OFF_DELAY(D)) uut (
    .clk(clk), .rst_n(rst_n), .wake_pin(wake_pin), .pwr_btn(pwr_btn),
    .alarm_hit(alarm_hit), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sci(sci), .onctl(onctl));

  always #10 clk = ~clk;

  function automatic bit lvl_m(int c, bit v);
    return (c == 1 && !v) || (c == 2 && v);
  endfunction
  function automatic bit edg_m(int c, bit a, bit b);
    return (c == 3 && a && !b) || (c == 4 && !a && b) || (c == 5 && a != b);
  endfunction

  task automatic chk(string rq, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic pulse_alarm();
    @(negedge clk); alarm_hit = 1;
    @(negedge clk); alarm_hit = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    int n;
    void'($urandom(32'd4242));
    cyc(3); rst_n = 1; cyc(2);

    // R1 reset state
    rd(0, r); chk("R1 sts", r, 0);
    rd(1, r); chk("R1 en", r, 0);
    rd(2, r); chk("R1 ctl", r, 0);
    rd(4, r); chk("R1 cfg", r, 0);
    chk("R1 sci", sci, 0);
    chk("R1 onctl", onctl, 1);

    // R11 reserved bits, R2 cfg field
    wr(1, 8'hFF); rd(1, r); chk("R11 en mask", r, 8'h3F);
    wr(1, 8'h00);
    wr(2, 8'h78); rd(2, r); chk("R11 ctl rsv", r, 0);
    rd(3, r); chk("R11 unmapped 3", r, 0);
    rd(15, r); chk("R11 unmapped 15", r, 0);
    wr(4 + 2, 8'hFD); rd(4 + 2, r); chk("R2 cfg pin2", r, 5);
    wr(4 + 2, 8'h00);

    // R7 button, R4 disabled source, R3 edge once
    @(negedge clk); pwr_btn = 1; cyc(5);
    rd(0, r); chk("R7 button sts", r, 8'h10);
    chk("R4 sci disabled", sci, 0);
    wr(0, 8'h10); cyc(5);
    rd(0, r); chk("R3 held button no reset", r, 0);
    @(negedge clk); pwr_btn = 0; cyc(4);

    // R7 alarm, R5 W1C, R6 sci hold
    pulse_alarm(); cyc(1);
    rd(0, r); chk("R7 alarm sts", r, 8'h20);
    wr(0, 8'h00); rd(0, r); chk("R5 write0 keeps", r, 8'h20);
    wr(1, 8'h20); cyc(1); chk("R6 sci on", sci, 1);
    cyc(10); chk("R6 sci held", sci, 1);
    wr(0, 8'h20); rd(0, r); chk("R5 w1c", r, 0);
    chk("R6 sci off", sci, 0);

    // R5 collision: level set vs clear
    @(negedge clk); alarm_hit = 1; cyc(1);
    wr(0, 8'h20); rd(0, r); chk("R5 set wins", r, 8'h20);
    @(negedge clk); alarm_hit = 0; cyc(1);
    wr(0, 8'h20); rd(0, r); chk("R5 cleared", r, 0);

    // R8 wake flag
    wr(2, 8'h01); rd(2, r); chk("R8 susp set", r, 8'h01);
    pulse_alarm(); cyc(1);
    rd(2, r); chk("R8 wake in susp", r, 8'h80);
    wr(2, 8'h80); rd(2, r); chk("R8 wake w1c", r, 0);
    wr(0, 8'hFF);
    pulse_alarm(); cyc(1);
    rd(2, r); chk("R8 no wake awake", r, 0);
    wr(0, 8'hFF); wr(1, 8'h00);
    wr(2, 8'h01); pulse_alarm(); cyc(1);
    rd(2, r); chk("R8 no wake disabled", r, 8'h01);
    wr(2, 8'h00); wr(0, 8'hFF);

    // R9 immediate off, R10 wake from off
    wr(2, 8'h04); chk("R9 immediate off", onctl, 0);
    wr(1, 8'h20); pulse_alarm(); cyc(1);
    chk("R10 on after event", onctl, 1);
    wr(0, 8'hFF); wr(1, 8'h00);

    // R9 delayed off
    wr(2, 8'h06);
    chk("R9 still on", onctl, 1);
    rd(2, r); chk("R9 delay running", r, 8'h06);
    n = 0;
    while (onctl && n < 100) begin @(posedge clk); #1; n++; end
    chk("R9 delay length", n, D);
    rd(2, r); chk("R9 after delay", r, 8'h02);
    wr(1, 8'h20); pulse_alarm(); cyc(1);
    chk("R10 on again", onctl, 1);
    wr(0, 8'hFF);

    // R10 cancel during delay
    wr(2, 8'h06); cyc(5);
    pulse_alarm(); cyc(D + 5);
    chk("R10 cancel on", onctl, 1);
    rd(2, r); chk("R10 cancel flag", r, 8'h02);
    wr(0, 8'hFF); wr(1, 8'h00); wr(2, 8'h00);

    // R2 R3 R4 R6 random pin trials
    for (int t = 0; t < 24; t++) begin
      int p = $urandom % NP;
      int c = $urandom % 8;
      bit e = $urandom % 2;
      bit v0 = $urandom % 2;
      bit ex;
      @(negedge clk); wake_pin[p] = v0; cyc(4);
      wr(4'(4 + p), 8'(c)); cyc(4);
      wr(0, 8'hFF); cyc(4);
      rd(0, r); chk("R2 level start", r[p], lvl_m(c, v0));
      wr(1, 8'(e) << p);
      @(negedge clk); wake_pin[p] = !v0; cyc(5);
      ex = lvl_m(c, v0) | lvl_m(c, !v0) | edg_m(c, v0, !v0);
      rd(0, r); chk("R3 trigger", r[p], ex);
      chk("R4 other bits", r & ~(8'd1 << p), 0);
      chk("R6 sci random", sci, ex & e);
      wr(4'(4 + p), 8'h00);
      @(negedge clk); wake_pin[p] = 0; cyc(4);
      wr(0, 8'hFF); wr(1, 8'h00);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule